// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block is the multi-cycle sequencer that carries out the stack and control-transfer work of an 8-bit processor core. It covers subroutine call and return, software break, return from interrupt, and push and pull of the accumulator and the status byte. It also runs the power-up sequence that fetches the start address. It owns the 8-bit stack pointer, the program counter, the accumulator and the status byte. All of its memory traffic goes through one byte-wide port with a 16-bit address.

An instruction decoder hands it one command at a time over a valid/ready pair. `cmd_ready` is high only while the sequencer is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_pc` is the address of the byte just after the opcode, and `cmd_arg` carries the call target or a load value. The decoder holds the command fields stable while `cmd_valid` is high and `cmd_ready` is low, because that is back-pressure. `done` pulses for one cycle when the sequence has finished.

The memory port has no bounded latency. The sequencer raises `mem_rd` or `mem_wr` and holds the address, the strobe and the write data until the memory answers with a one-cycle `mem_ack`. Read data is taken in the same cycle as that acknowledge.

Top module: `stk_seq`

## Requirements
- R1: While reset is low, the accumulator, the status byte and the stack pointer are cleared to zero. After reset the block reads 0xFFFC and then 0xFFFD, loads the program counter with {byte at 0xFFFD, byte at 0xFFFC}, and only then raises `cmd_ready`.
- R2: Every stack access addresses 0x0100 plus the stack pointer. A push writes at the stack pointer and then decrements it. A pull first increments the stack pointer and then reads there. The stack pointer wraps modulo 256.
- R3: `mem_addr`, the active strobe and `mem_wdata` stay unchanged until `mem_ack`. `mem_rd` and `mem_wr` are never high together, and only one access is outstanding.
- R4: Call (op 0) pushes the value `cmd_pc`+1: the high byte first, then the low byte. It then sets the program counter to `cmd_arg`.
- R5: Return (op 1) pulls the low byte and then the high byte, and sets the program counter to that word plus one.
- R6: Break (op 2) pushes `cmd_pc`+1 (high byte, then low byte) and then the status byte with bit 4 (break) and bit 5 set. It then sets bits 4 and 2 (interrupt disable) in the status byte, reads 0xFFFE (low) and 0xFFFF (high), and loads the program counter from them.
- R7: Return from interrupt (op 3) pulls the status byte, which replaces the whole status register, then pulls the program counter low and high bytes. No increment is applied.
- R8: Push accumulator (op 4) writes the accumulator. Pull accumulator (op 5) loads it and sets bit 7 (N) to its bit 7 and bit 1 (Z) to whether it is zero, leaving the other status bits alone.
- R9: Push status (op 6) writes the status byte with bit 5 forced to 1 and leaves the status register unchanged. Pull status (op 7) replaces all eight status bits.
- R10: Ops 8, 9 and 10 load the accumulator, the status byte and the stack pointer from `cmd_arg[7:0]` without any memory access. Ops 11 to 15 make no access and change no state.
- R11: `done` is high for exactly one cycle. It comes in the cycle after the final acknowledge, or in the cycle after acceptance for a command with no access. `cmd_ready` is low from acceptance through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered by the decoder |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 4 | Operation code (0..10 defined) |
| cmd_pc | input | 16 | Address following the opcode byte |
| cmd_arg | input | 16 | Call target, or load value in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe, held until acknowledge |
| mem_wr | output | 1 | Write strobe, held until acknowledge |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with acknowledge |
| mem_ack | input | 1 | One-cycle access acknowledge |
| pc | output | 16 | Program counter |
| acc | output | 8 | Accumulator |
| status | output | 8 | Status byte |
| sp | output | 8 | Stack pointer |

## Verification
A stack pointer that is off by one shows up at the next stack access: the written or read address differs from 0x0100 plus the expected pointer in that same cycle. The same error is visible on `sp` at completion. A wrong sequencing state shows as a byte order swap or a missing access in the acknowledge log within one command, or as a wrong program counter when `done` pulses. Corrupted status packing is seen directly in the written byte of a status push, and in `status` right after a break or a pull.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    OP_CALL = 4'd0,
    OP_RET  = 4'd1,
    OP_BRK  = 4'd2,
    OP_RTI  = 4'd3,
    OP_PSHA = 4'd4,
    OP_PULA = 4'd5,
    OP_PSHP = 4'd6,
    OP_PULP = 4'd7,
    OP_LDA  = 4'd8,
    OP_LDP  = 4'd9,
    OP_LDSP = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    ST_RVLO, ST_RVHI, ST_IDLE,
    ST_PCH_W, ST_PCL_W, ST_P_W, ST_A_W,
    ST_BVLO, ST_BVHI,
    ST_P_R, ST_PCL_R, ST_PCH_R, ST_A_R,
    ST_DONE
  } state_e;

  localparam int FB_N   = 7;
  localparam int FB_ONE = 5;
  localparam int FB_BRK = 4;
  localparam int FB_I   = 2;
  localparam int FB_Z   = 1;

endpackage

// File: rtl/stk_sp.sv
module stk_sp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] sp_up
);
  logic [DW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= '0;
    else if (load) sp_q <= load_val;
    else if (inc)  sp_q <= sp_q + 1'b1;
    else if (dec)  sp_q <= sp_q - 1'b1;
  end

  assign sp    = sp_q;
  assign sp_up = sp_q + 1'b1;
endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_load,
  input  logic          a_nz,
  input  logic [DW-1:0] a_val,
  input  logic          p_load,
  input  logic [DW-1:0] p_val,
  input  logic          p_brk,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] status
);
  logic [DW-1:0] acc_q, st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      st_q  <= '0;
    end else begin
      if (a_load) begin
        acc_q <= a_val;
        if (a_nz) begin
          st_q[FB_N] <= a_val[DW-1];
          st_q[FB_Z] <= (a_val == '0);
        end
      end
      if (p_load) st_q <= p_val;
      else if (p_brk) begin
        st_q[FB_BRK] <= 1'b1;
        st_q[FB_I]   <= 1'b1;
      end
    end
  end

  assign acc    = acc_q;
  assign status = st_q;
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 1,
  parameter logic [AW-1:0] RST_VEC = 16'hFFFC,
  parameter logic [AW-1:0] BRK_VEC = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_pc,
  input  logic [AW-1:0] cmd_arg,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [AW-1:0] pc,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] sp_up,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] status,
  output logic          sp_inc,
  output logic          sp_dec,
  output logic          sp_load,
  output logic [DW-1:0] sp_val,
  output logic          a_load,
  output logic          a_nz,
  output logic [DW-1:0] a_val,
  output logic          p_load,
  output logic [DW-1:0] p_val,
  output logic          p_brk
);
  localparam logic [DW-1:0] ONE_MASK = DW'(1) << FB_ONE;
  localparam logic [DW-1:0] BRK_MASK = DW'(1) << FB_BRK;

  state_e        st_q, st_d;
  op_e           op_q;
  logic [AW-1:0] ret_q, tgt_q, pc_q;
  logic [DW-1:0] lo_q;
  logic          is_pull, xfer, accept;
  op_e           cop;

  assign cop    = op_e'(cmd_op);
  assign accept = cmd_valid && (st_q == ST_IDLE);

  // Strobes and address per state
  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    is_pull   = 1'b0;
    unique case (st_q)
      ST_RVLO:  begin mem_rd = 1'b1; mem_addr = RST_VEC; end
      ST_RVHI:  begin mem_rd = 1'b1; mem_addr = RST_VEC + 1'b1; end
      ST_BVLO:  begin mem_rd = 1'b1; mem_addr = BRK_VEC; end
      ST_BVHI:  begin mem_rd = 1'b1; mem_addr = BRK_VEC + 1'b1; end
      ST_PCH_W: begin mem_wr = 1'b1; mem_wdata = ret_q[AW-1:AW-DW]; end
      ST_PCL_W: begin mem_wr = 1'b1; mem_wdata = ret_q[DW-1:0]; end
      ST_P_W:   begin
        mem_wr    = 1'b1;
        mem_wdata = status | ONE_MASK | ((op_q == OP_BRK) ? BRK_MASK : '0);
      end
      ST_A_W:   begin mem_wr = 1'b1; mem_wdata = acc; end
      ST_P_R, ST_PCL_R, ST_PCH_R, ST_A_R: begin
        mem_rd  = 1'b1;
        is_pull = 1'b1;
      end
      default: ;
    endcase
    if (mem_wr) mem_addr = {STACK_PAGE, sp};
    if (is_pull) mem_addr = {STACK_PAGE, sp_up};
  end

  assign xfer   = (mem_rd || mem_wr) && mem_ack;
  assign sp_dec = mem_wr && mem_ack;
  assign sp_inc = is_pull && mem_ack;

  // Next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        unique case (cop)
          OP_CALL, OP_BRK: st_d = ST_PCH_W;
          OP_RET:          st_d = ST_PCL_R;
          OP_RTI, OP_PULP: st_d = ST_P_R;
          OP_PSHA:         st_d = ST_A_W;
          OP_PULA:         st_d = ST_A_R;
          OP_PSHP:         st_d = ST_P_W;
          default:         st_d = ST_DONE;
        endcase
      end
      ST_RVLO:  if (xfer) st_d = ST_RVHI;
      ST_RVHI:  if (xfer) st_d = ST_IDLE;
      ST_PCH_W: if (xfer) st_d = ST_PCL_W;
      ST_PCL_W: if (xfer) st_d = (op_q == OP_BRK) ? ST_P_W : ST_DONE;
      ST_P_W:   if (xfer) st_d = (op_q == OP_BRK) ? ST_BVLO : ST_DONE;
      ST_BVLO:  if (xfer) st_d = ST_BVHI;
      ST_BVHI:  if (xfer) st_d = ST_DONE;
      ST_P_R:   if (xfer) st_d = (op_q == OP_RTI) ? ST_PCL_R : ST_DONE;
      ST_PCL_R: if (xfer) st_d = ST_PCH_R;
      ST_PCH_R: if (xfer) st_d = ST_DONE;
      ST_A_W, ST_A_R: if (xfer) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Register side effects
  always_comb begin
    sp_load = accept && (cop == OP_LDSP);
    sp_val  = cmd_arg[DW-1:0];
    a_load  = 1'b0;
    a_nz    = 1'b0;
    a_val   = cmd_arg[DW-1:0];
    p_load  = 1'b0;
    p_val   = cmd_arg[DW-1:0];
    p_brk   = (st_q == ST_P_W) && xfer && (op_q == OP_BRK);
    if (accept && cop == OP_LDA) a_load = 1'b1;
    if (accept && cop == OP_LDP) p_load = 1'b1;
    if (st_q == ST_A_R && xfer) begin
      a_load = 1'b1;
      a_nz   = 1'b1;
      a_val  = mem_rdata;
    end
    if (st_q == ST_P_R && xfer) begin
      p_load = 1'b1;
      p_val  = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_RVLO;
      op_q  <= OP_CALL;
      ret_q <= '0;
      tgt_q <= '0;
      pc_q  <= '0;
      lo_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q  <= cop;
        ret_q <= cmd_pc + 1'b1;
        tgt_q <= cmd_arg;
      end
      if (xfer && (st_q == ST_RVLO || st_q == ST_BVLO || st_q == ST_PCL_R))
        lo_q <= mem_rdata;
      if (xfer && (st_q == ST_RVHI || st_q == ST_BVHI))
        pc_q <= {mem_rdata, lo_q};
      if (xfer && st_q == ST_PCH_R)
        pc_q <= {mem_rdata, lo_q} + ((op_q == OP_RET) ? AW'(1) : AW'(0));
      if (xfer && st_q == ST_PCL_W && op_q == OP_CALL)
        pc_q <= tgt_q;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign pc        = pc_q;
endmodule

// File: rtl/stk_seq.sv
module stk_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 1,
  parameter logic [AW-1:0] RST_VEC = 16'hFFFC,
  parameter logic [AW-1:0] BRK_VEC = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_pc,
  input  logic [AW-1:0] cmd_arg,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] status,
  output logic [DW-1:0] sp
);
  logic          sp_inc, sp_dec, sp_load, a_load, a_nz, p_load, p_brk;
  logic [DW-1:0] sp_val, sp_up, a_val, p_val;

  stk_sp #(.DW(DW)) u_sp (
    .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec),
    .load(sp_load), .load_val(sp_val), .sp(sp), .sp_up(sp_up)
  );

  stk_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .a_load(a_load), .a_nz(a_nz), .a_val(a_val),
    .p_load(p_load), .p_val(p_val), .p_brk(p_brk), .acc(acc), .status(status)
  );

  stk_ctrl #(
    .AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE), .RST_VEC(RST_VEC), .BRK_VEC(BRK_VEC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .cmd_arg(cmd_arg), .done(done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pc(pc), .sp(sp), .sp_up(sp_up),
    .acc(acc), .status(status), .sp_inc(sp_inc), .sp_dec(sp_dec),
    .sp_load(sp_load), .sp_val(sp_val), .a_load(a_load), .a_nz(a_nz),
    .a_val(a_val), .p_load(p_load), .p_val(p_val), .p_brk(p_brk)
  );
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [DW-1:0] sp
);
  logic [DW-1:0] sp_plus;
  assign sp_plus = sp + 1'b1;

  // R3
  p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack) |=>
      ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr)));

  // R3
  p_hold_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> $stable(mem_wdata));

  // R2
  p_push_at_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == {STACK_PAGE, sp}));

  // R2
  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ack) |=> (sp == $past(sp) - 1'b1));

  // R2
  p_pull_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr[AW-1:DW] == STACK_PAGE) |-> (mem_addr[DW-1:0] == sp_plus));

  // R2
  p_pull_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ack && mem_addr[AW-1:DW] == STACK_PAGE) |=>
      (sp == $past(sp) + 1'b1));

  // R11
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_rd && !mem_wr && !done));
endmodule

bind stk_seq stk_seq_chk #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .sp(sp)
);

// File: tb/sim_stk_seq.sv
`timescale 1ns/1ps
module sim_stk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [15:0] cmd_pc = '0, cmd_arg = '0;
  logic        done;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [15:0] pc;
  logic [7:0]  acc, status, sp;

  always #5 clk = ~clk;

  stk_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .cmd_arg(cmd_arg), .done(done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pc(pc), .acc(acc),
    .status(status), .sp(sp)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, wcnt = 0, hold_viol = 0;
  logic [7:0]  stk_mem [0:255];
  logic [7:0]  vec [0:3];
  logic [15:0] hold_addr;
  logic [15:0] log_a [0:7];
  logic        log_w [0:7];
  logic [7:0]  log_d [0:7];
  int          log_n = 0;

  // Memory responder: acknowledges after lat wait cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_rd || mem_wr) begin
      if (wcnt == 0) hold_addr = mem_addr;
      else if (mem_addr != hold_addr) hold_viol++;
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        mem_ack = 1'b1;
        if (mem_wr) begin
          if (mem_addr[15:8] == 8'h01) stk_mem[mem_addr[7:0]] = mem_wdata;
        end else if (mem_addr[15:8] == 8'h01) mem_rdata = stk_mem[mem_addr[7:0]];
        else if (mem_addr >= 16'hFFFC) mem_rdata = vec[mem_addr[1:0]];
        else mem_rdata = 8'h00;
        if (log_n < 8) begin
          log_a[log_n] = mem_addr;
          log_w[log_n] = mem_wr;
          log_d[log_n] = mem_wr ? mem_wdata : mem_rdata;
        end
        log_n++;
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input string tag, input int i, input logic w,
                         input logic [15:0] a, input logic [7:0] d);
    chk({tag, " dir"},  16'(log_w[i]), 16'(w));
    chk({tag, " addr"}, log_a[i], a);
    chk({tag, " data"}, 16'(log_d[i]), 16'(d));
  endtask

  task automatic run_cmd(input logic [3:0] op, input logic [15:0] cpc, input logic [15:0] arg);
    int n;
    log_n = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = cpc; cmd_arg = arg;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk("R11 done seen", 16'(done), 16'd1);
    chk("R11 ready low at done", 16'(cmd_ready), 16'd0);
    @(negedge clk);
    chk("R11 done one cycle", 16'(done), 16'd0);
    chk("R11 ready back", 16'(cmd_ready), 16'd1);
  endtask

  task automatic t_reset();
    int n;
    vec[0] = 8'h34; vec[1] = 8'h12; vec[2] = 8'h00; vec[3] = 8'h90;
    for (int i = 0; i < 256; i++) stk_mem[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 acc reset", 16'(acc), 16'h0);
    chk("R1 status reset", 16'(status), 16'h0);
    chk("R1 sp reset", 16'(sp), 16'h0);
    log_n = 0;
    rst_n = 1'b1;
    n = 0;
    while (!cmd_ready && n < 50) begin @(negedge clk); n++; end
    chk("R1 pc from vector", pc, 16'h1234);
    chk("R1 access count", 16'(log_n), 16'd2);
    chk_log("R1 vec lo", 0, 1'b0, 16'hFFFC, 8'h34);
    chk_log("R1 vec hi", 1, 1'b0, 16'hFFFD, 8'h12);
  endtask

  task automatic t_loads();
    run_cmd(4'd10, 16'h0, 16'h00FF);
    run_cmd(4'd8,  16'h0, 16'h005A);
    run_cmd(4'd9,  16'h0, 16'h00C3);
    chk("R10 sp load", 16'(sp), 16'h00FF);
    chk("R10 acc load", 16'(acc), 16'h005A);
    chk("R10 status load", 16'(status), 16'h00C3);
    chk("R10 no access", 16'(log_n), 16'd0);
  endtask

  task automatic t_push_a_p();
    run_cmd(4'd4, 16'h0, 16'h0);
    chk_log("R8 push acc", 0, 1'b1, 16'h01FF, 8'h5A);
    chk("R2 sp after push", 16'(sp), 16'h00FE);
    run_cmd(4'd6, 16'h0, 16'h0);
    chk_log("R9 push status bit5", 0, 1'b1, 16'h01FE, 8'hE3);
    chk("R9 status unchanged", 16'(status), 16'h00C3);
    chk("R2 sp after push p", 16'(sp), 16'h00FD);
  endtask

  task automatic t_call_ret();
    run_cmd(4'd0, 16'h2001, 16'h3000);
    chk("R4 two writes", 16'(log_n), 16'd2);
    chk_log("R4 push hi", 0, 1'b1, 16'h01FD, 8'h20);
    chk_log("R4 push lo", 1, 1'b1, 16'h01FC, 8'h02);
    chk("R4 pc target", pc, 16'h3000);
    chk("R4 sp", 16'(sp), 16'h00FB);
    run_cmd(4'd1, 16'h0, 16'h0);
    chk_log("R5 pull lo", 0, 1'b0, 16'h01FC, 8'h02);
    chk_log("R5 pull hi", 1, 1'b0, 16'h01FD, 8'h20);
    chk("R5 pc plus one", pc, 16'h2003);
    chk("R5 sp", 16'(sp), 16'h00FD);
  endtask

  task automatic t_pulls();
    run_cmd(4'd7, 16'h0, 16'h0);
    chk_log("R9 pull status", 0, 1'b0, 16'h01FE, 8'hE3);
    chk("R9 status replaced", 16'(status), 16'h00E3);
    run_cmd(4'd5, 16'h0, 16'h0);
    chk("R8 acc pulled", 16'(acc), 16'h005A);
    chk("R8 nz clear", 16'(status), 16'h0061);
    chk("R2 sp ff", 16'(sp), 16'h00FF);
    stk_mem[0] = 8'h00; stk_mem[1] = 8'h80;
    run_cmd(4'd5, 16'h0, 16'h0);
    chk("R2 pull wraps to 0100", log_a[0], 16'h0100);
    chk("R8 z set", 16'(status), 16'h0063);
    chk("R2 sp wrap 00", 16'(sp), 16'h0000);
    run_cmd(4'd5, 16'h0, 16'h0);
    chk("R8 acc neg", 16'(acc), 16'h0080);
    chk("R8 n set z clear", 16'(status), 16'h00E1);
  endtask

  task automatic t_push_wrap();
    run_cmd(4'd10, 16'h0, 16'h0000);
    run_cmd(4'd4, 16'h0, 16'h0);
    chk_log("R2 push at 0100", 0, 1'b1, 16'h0100, 8'h80);
    chk("R2 sp wrap ff", 16'(sp), 16'h00FF);
  endtask

  task automatic t_brk_rti();
    lat = 2;
    run_cmd(4'd10, 16'h0, 16'h0080);
    run_cmd(4'd9,  16'h0, 16'h0001);
    run_cmd(4'd2,  16'h4001, 16'h0);
    chk("R6 access count", 16'(log_n), 16'd5);
    chk_log("R6 push hi", 0, 1'b1, 16'h0180, 8'h40);
    chk_log("R6 push lo", 1, 1'b1, 16'h017F, 8'h02);
    chk_log("R6 push status", 2, 1'b1, 16'h017E, 8'h31);
    chk_log("R6 vec lo", 3, 1'b0, 16'hFFFE, 8'h00);
    chk_log("R6 vec hi", 4, 1'b0, 16'hFFFF, 8'h90);
    chk("R6 pc vector", pc, 16'h9000);
    chk("R6 status b and i", 16'(status), 16'h0015);
    chk("R6 sp", 16'(sp), 16'h007D);
    chk("R3 held while waiting", 16'(hold_viol), 16'd0);
    run_cmd(4'd3, 16'h0, 16'h0);
    chk_log("R7 pull status first", 0, 1'b0, 16'h017E, 8'h31);
    chk("R7 status", 16'(status), 16'h0031);
    chk("R7 pc no increment", pc, 16'h4002);
    chk("R7 sp", 16'(sp), 16'h0080);
    lat = 0;
  endtask

  task automatic t_unknown();
    run_cmd(4'd12, 16'h5555, 16'hFFFF);
    chk("R10 unknown no access", 16'(log_n), 16'd0);
    chk("R10 unknown pc", pc, 16'h4002);
    chk("R10 unknown acc", 16'(acc), 16'h0080);
    chk("R10 unknown status", 16'(status), 16'h0031);
    chk("R10 unknown sp", 16'(sp), 16'h0080);
  endtask

  initial begin
    t_reset();
    t_loads();
    t_push_a_p();
    t_call_ret();
    t_pulls();
    t_push_wrap();
    t_brk_rti();
    t_unknown();
    report();
  end
endmodule